// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

The block is a non-blocking time-slot switch for framed serial links. Each of `N_STR` serial inputs carries `N_CH` byte-wide channels per frame. Every input byte is gathered from the line, most significant bit first, and stored in a two-bank data memory. The bank is chosen by frame parity and the address is the channel counter, which the frame pulse restarts. Each output stream sends `N_CH` channels per frame at the same bit rate. For every output channel, a 16-bit connection word decides what is sent. The word can name any input stream and channel, and several outputs may name the same one. In processor mode the word instead carries a byte that is sent again in every frame.

A simple processor port writes and reads the connection words and one control register. A written word is used from the next frame boundary on. Each output stream has an output-enable signal that stands in for a high-impedance driver. That enable is the AND of three things: the per-channel enable bit of the word, the `master_en_i` pin, and the standby bit of the control register. The clock runs at twice the serial bit rate, so one bit cell lasts two clocks and one channel lasts 16 clocks.

Top module: `tsi_switch_core`

## Requirements
- R1: After reset every `tx_oe_o` bit is 0, and the processor port reads 0 from both connection word 0 and the control register.
- R2: In connection mode (bit 15 = 0) the output byte comes from input stream `word[6:5]` and channel `word[4:0]` (with the default parameters). Word bits 11 to 7 are ignored. Several outputs may select the same source.
- R3: In processor mode (bit 15 = 1) the output channel sends `word[7:0]` in every frame.
- R4: With constant delay (bit 14 = 1) a connection-mode channel sends the source byte received in the previous frame.
- R5: With variable delay (bit 14 = 0), output channel c sends the source byte from the current frame when the source channel is below c. Otherwise it sends the byte from the previous frame. For output channel 0 this is always the previous frame.
- R6: Word bit 13 is the per-channel output enable. While it is 0, that stream's `tx_oe_o` is 0 for the whole channel.
- R7: `tx_oe_o` is 0 on all streams while `master_en_i` is low or while control register bit 0 (processor address bit 7 = 1) is 0. Both controls act at once, with no frame delay.
- R8: A processor write is read back on `cpu_rdata_o` from the next cycle on. A connection word that is written takes effect from the next frame boundary.
- R9: When `fp_i` is sampled high, the next cycle is cycle 0 of channel 0. A bit cell is two clocks, and bits are sent and received most significant bit first. Input is sampled at the end of the first clock of each cell, and `tx_o` holds steady through each cell.
- R10: Word bit 12 (loopback control) is stored and read back, and it has no effect on the output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame pulse; the cycle after it is frame cycle 0 |
| rx_i | input | N_STR | Serial input streams |
| tx_o | output | N_STR | Serial output streams |
| tx_oe_o | output | N_STR | Per-stream output enable for the current channel |
| master_en_i | input | 1 | Master output enable pin |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_addr_i | input | CM_AW+1 | {control select, stream, channel} |
| cpu_wdata_i | input | 16 | Processor write data |
| cpu_rdata_o | output | 16 | Processor read data for `cpu_addr_i` |

## Verification
New random input bytes arrive every frame. The connection words are a random mix of modes, sources, enables and values in the ignored bits, so a wrong source field or a wrong bank shows up as a byte mismatch. Directed words place variable-delay sources just below, equal to and above the output channel, and at the wrap from the last channel to channel 0, which separates current-frame reads from previous-frame reads. A connection word written mid-frame for a later channel shows whether the update waits for the frame boundary. The master pin and the standby bit are each dropped mid-frame to show that the enable gating acts at once.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int BYTE_W   = 8;
   localparam int CW_W     = 16;
   localparam int CW_PROC  = 15;  // 1: send word byte, 0: switch a source
   localparam int CW_CONST = 14;  // 1: previous-frame source byte
   localparam int CW_OE    = 13;  // per-channel output enable
   localparam int CW_LOOP  = 12;  // loopback control, stored only
   localparam int CELL_CYC = 2;   // clocks per bit cell
endpackage

// File: rtl/tsi_rx_deser.sv
module tsi_rx_deser #(
   parameter int BW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          rx_i,
   input  logic          sample_i,
   output logic [BW-1:0] byte_o
);
   logic [BW-2:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sh_q <= '0;
      else if (sample_i) sh_q <= {sh_q[BW-3:0], rx_i};
   end

   // last bit joins the byte in the cycle it is sampled
   assign byte_o = {sh_q, rx_i};
endmodule

// File: rtl/tsi_tx_ser.sv
module tsi_tx_ser #(
   parameter int BW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic          shift_i,
   input  logic [BW-1:0] byte_i,
   input  logic          oe_i,
   output logic          tx_o,
   output logic          oe_o
);
   logic [BW-1:0] sh_q;
   logic          oe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q <= '0;
         oe_q <= 1'b0;
      end else if (load_i) begin
         sh_q <= byte_i;
         oe_q <= oe_i;
      end else if (shift_i) begin
         sh_q <= {sh_q[BW-2:0], 1'b0};
      end
   end

   assign tx_o = sh_q[BW-1];
   assign oe_o = oe_q;
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
   parameter int N_STR = 4,
   parameter int N_CH  = 32,
   parameter int BW    = 8,
   localparam int ST_W = $clog2(N_STR),
   localparam int CH_W = $clog2(N_CH)
) (
   input  logic                            clk_i,
   input  logic                            wr_en_i,
   input  logic                            wr_bank_i,
   input  logic [CH_W-1:0]                 wr_ch_i,
   input  logic [N_STR-1:0][BW-1:0]        wr_data_i,
   input  logic [N_STR-1:0]                rd_bank_i,
   input  logic [N_STR-1:0][ST_W-1:0]      rd_st_i,
   input  logic [N_STR-1:0][CH_W-1:0]      rd_ch_i,
   output logic [N_STR-1:0][BW-1:0]        rd_data_o
);
   logic [BW-1:0] mem_q [2][N_STR][N_CH];

   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         for (int s = 0; s < N_STR; s++)
            mem_q[wr_bank_i][s][wr_ch_i] <= wr_data_i[s];
      end
   end

   for (genvar s = 0; s < N_STR; s++) begin : g_rd
      assign rd_data_o[s] = mem_q[rd_bank_i[s]][rd_st_i[s]][rd_ch_i[s]];
   end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
   parameter int N_STR = 4,
   parameter int N_CH  = 32,
   parameter int CW    = 16,
   localparam int ST_W = $clog2(N_STR),
   localparam int CH_W = $clog2(N_CH),
   localparam int AW   = ST_W + CH_W
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     we_i,
   input  logic [AW-1:0]            addr_i,
   input  logic [CW-1:0]            wdata_i,
   output logic [CW-1:0]            rdata_o,
   input  logic                     commit_i,
   input  logic [CH_W-1:0]          fetch_ch_i,
   output logic [N_STR-1:0][CW-1:0] fetch_word_o
);
   logic [CW-1:0] pend_q [N_STR][N_CH];
   logic [CW-1:0] act_q  [N_STR][N_CH];
   logic [ST_W-1:0] a_st;
   logic [CH_W-1:0] a_ch;

   assign a_st = addr_i[AW-1:CH_W];
   assign a_ch = addr_i[CH_W-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < N_STR; s++)
            for (int c = 0; c < N_CH; c++) begin
               pend_q[s][c] <= '0;
               act_q[s][c]  <= '0;
            end
      end else begin
         if (we_i) pend_q[a_st][a_ch] <= wdata_i;
         if (commit_i) act_q <= pend_q;
      end
   end

   assign rdata_o = pend_q[a_st][a_ch];

   // at the frame boundary the new words are already the ones in force
   for (genvar s = 0; s < N_STR; s++) begin : g_fetch
      assign fetch_word_o[s] = commit_i ? pend_q[s][fetch_ch_i]
                                        : act_q[s][fetch_ch_i];
   end
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core #(
   parameter int N_STR = 4,
   parameter int N_CH  = 32,
   localparam int ST_W  = $clog2(N_STR),
   localparam int CH_W  = $clog2(N_CH),
   localparam int CM_AW = ST_W + CH_W,
   localparam int CYC_W = CH_W + 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 fp_i,
   input  logic [N_STR-1:0]     rx_i,
   output logic [N_STR-1:0]     tx_o,
   output logic [N_STR-1:0]     tx_oe_o,
   input  logic                 master_en_i,
   input  logic                 cpu_we_i,
   input  logic [CM_AW:0]       cpu_addr_i,
   input  logic [15:0]          cpu_wdata_i,
   output logic [15:0]          cpu_rdata_o
);
   import tsi_pkg::*;

   if (N_STR < 2 || (1 << ST_W) != N_STR) begin : g_bad_str
      $error("N_STR must be a power of two and at least 2");
   end
   if (N_CH < 2 || (1 << CH_W) != N_CH) begin : g_bad_ch
      $error("N_CH must be a power of two and at least 2");
   end
   if (CM_AW > 12) begin : g_bad_aw
      $error("source field must fit below the control bits");
   end
   if (CELL_CYC * BYTE_W != 16) begin : g_bad_cell
      $error("channel timing assumes 16 clocks per channel");
   end

   localparam logic [CYC_W-1:0] CYC_MAX = '1;

   logic [CYC_W-1:0] cyc_q;
   logic             wbank_q;
   logic             standby_q;
   logic             boundary, fetch, rx_last;
   logic [CH_W-1:0]  cur_ch, tgt_ch;
   logic [CW_W-1:0]  cm_rdata;
   logic             ctrl_sel;

   logic [N_STR-1:0][CW_W-1:0]   word;
   logic [N_STR-1:0][BYTE_W-1:0] rx_byte, mem_byte, tx_byte;
   logic [N_STR-1:0][ST_W-1:0]   src_st;
   logic [N_STR-1:0][CH_W-1:0]   src_ch;
   logic [N_STR-1:0]             rd_bank, ch_oe;

   assign boundary = fp_i | (cyc_q == CYC_MAX);
   assign cur_ch   = cyc_q[CYC_W-1:4];
   assign fetch    = boundary | (cyc_q[3:0] == 4'hF);
   assign tgt_ch   = boundary ? '0 : cur_ch + 1'b1;
   assign rx_last  = (cyc_q[3:0] == 4'hE);
   assign ctrl_sel = cpu_addr_i[CM_AW];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cyc_q     <= '0;
         wbank_q   <= 1'b0;
         standby_q <= 1'b0;
      end else begin
         cyc_q <= fp_i ? '0 : cyc_q + 1'b1;
         if (boundary) wbank_q <= ~wbank_q;
         if (cpu_we_i && ctrl_sel) standby_q <= cpu_wdata_i[0];
      end
   end

   assign cpu_rdata_o = ctrl_sel ? {{(CW_W-1){1'b0}}, standby_q} : cm_rdata;

   tsi_conn_mem #(.N_STR(N_STR), .N_CH(N_CH), .CW(CW_W)) u_cmem (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .we_i         (cpu_we_i & ~ctrl_sel),
      .addr_i       (cpu_addr_i[CM_AW-1:0]),
      .wdata_i      (cpu_wdata_i),
      .rdata_o      (cm_rdata),
      .commit_i     (boundary),
      .fetch_ch_i   (tgt_ch),
      .fetch_word_o (word)
   );

   tsi_data_mem #(.N_STR(N_STR), .N_CH(N_CH), .BW(BYTE_W)) u_dmem (
      .clk_i     (clk_i),
      .wr_en_i   (rx_last),
      .wr_bank_i (wbank_q),
      .wr_ch_i   (cur_ch),
      .wr_data_i (rx_byte),
      .rd_bank_i (rd_bank),
      .rd_st_i   (src_st),
      .rd_ch_i   (src_ch),
      .rd_data_o (mem_byte)
   );

   for (genvar s = 0; s < N_STR; s++) begin : g_str
      logic unused_w;
      assign unused_w  = ^{word[s][CW_LOOP:CM_AW]};
      assign src_st[s] = word[s][CM_AW-1:CH_W];
      assign src_ch[s] = word[s][CH_W-1:0];

      // constant delay: whole previous frame; variable: newest written byte
      always_comb begin
         if (word[s][CW_CONST])
            rd_bank[s] = boundary ? wbank_q : ~wbank_q;
         else
            rd_bank[s] = (boundary || src_ch[s] <= cur_ch) ? wbank_q : ~wbank_q;
      end

      assign tx_byte[s] = word[s][CW_PROC] ? word[s][BYTE_W-1:0] : mem_byte[s];

      tsi_rx_deser #(.BW(BYTE_W)) u_rx (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .rx_i     (rx_i[s]),
         .sample_i (~cyc_q[0]),
         .byte_o   (rx_byte[s])
      );

      tsi_tx_ser #(.BW(BYTE_W)) u_tx (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .load_i  (fetch),
         .shift_i (cyc_q[0]),
         .byte_i  (tx_byte[s]),
         .oe_i    (word[s][CW_OE]),
         .tx_o    (tx_o[s]),
         .oe_o    (ch_oe[s])
      );

      assign tx_oe_o[s] = ch_oe[s] & master_en_i & standby_q;
   end
endmodule

// File: rtl/tsi_switch_checker.sv
module tsi_switch_checker #(
   parameter int N_STR = 4,
   parameter int CYC_W = 9
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             fp_i,
   input logic             master_en_i,
   input logic             standby_q,
   input logic [CYC_W-1:0] cyc_q,
   input logic [N_STR-1:0] tx_o,
   input logic [N_STR-1:0] tx_oe_o
);
   // R7: master pin forces every output off
   p_master_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !master_en_i |-> tx_oe_o == '0);

   // R7: standby bit forces every output off
   p_standby_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !standby_q |-> tx_oe_o == '0);

   // R9: serial data holds through both clocks of a bit cell
   p_bit_cell_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fp_i && !cyc_q[0]) |=> $stable(tx_o));

   // R9: frame pulse restarts the frame at cycle 0
   p_frame_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fp_i |=> cyc_q == '0);
endmodule

bind tsi_switch_core tsi_switch_checker #(.N_STR(N_STR), .CYC_W(CYC_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .fp_i        (fp_i),
   .master_en_i (master_en_i),
   .standby_q   (standby_q),
   .cyc_q       (cyc_q),
   .tx_o        (tx_o),
   .tx_oe_o     (tx_oe_o)
);

// File: tb/tsi_switch_core_test.sv
`timescale 1ns/1ps
module tsi_switch_core_test;
   localparam int NS = 4;
   localparam int NC = 32;
   localparam int FR = NC * 16;
   localparam logic [7:0] CTRL_A = 8'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fp = 1'b0;
   logic [NS-1:0] rx = '0;
   logic [NS-1:0] tx, tx_oe;
   logic          men = 1'b1;
   logic          we = 1'b0;
   logic [7:0]    addr = '0;
   logic [15:0]   wdata = '0;
   logic [15:0]   rdata;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0]  in_cur  [NS][NC];
   logic [7:0]  in_prev [NS][NC];
   logic [15:0] pend    [NS][NC];
   logic [15:0] act     [NS][NC];
   logic        ctrl_en = 1'b0;
   logic [7:0]  cap     [NS];

   always #2.5 clk = ~clk;

   tsi_switch_core #(.N_STR(NS), .N_CH(NC)) uut (
      .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .rx_i(rx), .tx_o(tx),
      .tx_oe_o(tx_oe), .master_en_i(men), .cpu_we_i(we),
      .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata));

   task automatic check(input bit ok, input string req, input int actv, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, actv, expv);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int s, input int c);
      logic [15:0] w;
      int st, sc;
      w = act[s][c];
      st = int'(w[6:5]);
      sc = int'(w[4:0]);
      if (w[15]) return w[7:0];
      if (w[14]) return in_prev[st][sc];
      if (c != 0 && sc < c) return in_cur[st][sc];
      return in_prev[st][sc];
   endfunction

   function automatic string byte_tag(input int s, input int c);
      string t;
      logic [15:0] w;
      w = act[s][c];
      if (w[15]) t = "R3 processor byte";
      else if (w[14]) t = "R4 constant delay R2";
      else t = "R5 variable delay R2";
      if (w[12]) t = {t, " R10"};
      return t;
   endfunction

   task automatic cpu_write(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
      if (a[7]) ctrl_en = d[0];
      else begin
         pend[a[6:5]][a[4:0]] = d;
         act[a[6:5]][a[4:0]]  = d;
      end
      check(rdata == (a[7] ? {15'b0, d[0]} : d), "R8 readback", int'(rdata), int'(d));
   endtask

   task automatic run_frame(input bit chk, input bit do_wr, input logic [7:0] wa,
                            input logic [15:0] wd, input bit drop_men);
      in_prev = in_cur;
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < NC; c++) in_cur[s][c] = 8'($urandom);
      act = pend;
      for (int i = 0; i < FR; i++) begin
         int ch, b;
         @(negedge clk);
         ch = i >> 4;
         b  = (i >> 1) & 7;
         for (int s = 0; s < NS; s++) begin
            if (i % 2 == 1) cap[s] = {cap[s][6:0], tx[s]};
            if (i % 16 == 15) begin
               logic eo;
               logic [7:0] eb;
               eo = act[s][ch][13] & men & ctrl_en;
               check(tx_oe[s] == eo, "R6 R7 output enable", int'(tx_oe[s]), int'(eo));
               if (chk && eo) begin
                  eb = exp_byte(s, ch);
                  check(cap[s] == eb, byte_tag(s, ch), int'(cap[s]), int'(eb));
               end
            end
         end
         fp = (i == FR - 1);
         for (int s = 0; s < NS; s++) rx[s] = in_cur[s][ch][7-b];
         if (i == 0) men = 1'b1;
         if (drop_men && i == 200) men = 1'b0;
         we = do_wr && (i == 100);
         if (do_wr && i == 100) begin
            addr = wa; wdata = wd;
            if (wa[7]) ctrl_en = wd[0];
            else pend[wa[6:5]][wa[4:0]] = wd;
         end
         if (do_wr && i == 102)
            check(rdata == (wa[7] ? {15'b0, wd[0]} : wd), "R8 mid-frame readback",
                  int'(rdata), int'(wd));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] w;
      void'($urandom(32'd1234));
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < NC; c++) begin
            in_cur[s][c] = '0; pend[s][c] = '0; act[s][c] = '0;
         end
      for (int s = 0; s < NS; s++) cap[s] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check(tx_oe == '0, "R1 reset enables", int'(tx_oe), 0);
      addr = 8'h00;
      #1 check(rdata == 16'h0, "R1 reset word", int'(rdata), 0);
      addr = CTRL_A;
      #1 check(rdata == 16'h0, "R1 reset control", int'(rdata), 0);

      cpu_write(CTRL_A, 16'h0001);
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < NC; c++) begin
            w = 16'($urandom);
            w[13] = ($urandom % 8) != 0;
            if (s == 3 && c < 8) w = 16'h6F87 & ~16'h8000;  // R2 broadcast of (0,7), junk in bits 11..7
            if (s == 3 && c < 4) w = 16'h2F87;                // R2 broadcast, variable delay
            if (s == 1 && c == 10) w = 16'h2009;               // R5 source just below output
            if (s == 1 && c == 11) w = 16'h200B;               // R5 source equal to output
            if (s == 1 && c == 0)  w = 16'h207F;               // R5 wrap to channel 0
            if (s == 0 && c == 1)  w = 16'h6000;               // R4 constant source (0,0)
            if (s == 0 && c == 2)  w = 16'hB03C;               // R3 processor byte, R10 bit set
            if (s == 0 && c == 3)  w = 16'h0045;               // R6 channel disabled
            cpu_write({1'b0, 2'(s), 5'(c)}, w);
         end

      @(negedge clk) fp = 1'b1;
      run_frame(1'b0, 1'b0, 8'h00, 16'h0, 1'b0);
      run_frame(1'b1, 1'b0, 8'h00, 16'h0, 1'b0);
      run_frame(1'b1, 1'b0, 8'h00, 16'h0, 1'b0);
      // R8: new word for a later channel waits for the next frame
      run_frame(1'b1, 1'b1, {1'b0, 2'd2, 5'd20}, 16'hA05A, 1'b0);
      run_frame(1'b1, 1'b0, 8'h00, 16'h0, 1'b0);
      // R7: master pin drops mid-frame
      run_frame(1'b1, 1'b0, 8'h00, 16'h0, 1'b1);
      // R7: standby bit cleared, then set again mid-frame
      run_frame(1'b1, 1'b1, CTRL_A, 16'h0000, 1'b0);
      run_frame(1'b1, 1'b1, CTRL_A, 16'h0001, 1'b0);
      run_frame(1'b1, 1'b0, 8'h00, 16'h0, 1'b0);
      @(negedge clk) fp = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule